// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block supervises power-up of the baseband. While it is off, it waits for a wake event. A wake event is a press of the power key (active low) or a charger being detected. On a wake event it turns on the supply enable, which feeds the receiver regulator and the controller. It then keeps the controller in reset until the PLL has settled and a further fixed hold time has passed.

Once the controller runs, the power key and the charger input are ignored. A watchdog then decides whether power is kept. Software reloads the watchdog with a one-cycle write strobe. If the watchdog is not reloaded in time, the block drops the supply and returns to off. Software can also switch the block off through a power-off strobe. An active-low low-battery input forces the block off from any state.

The four pin inputs pass through a synchroniser of `SYNC_STAGES` flops. The two software strobes are already synchronous and act on the next clock edge.

Top module: `pwr_sup`

## Requirements
- R1: From off, power-up starts only when the synchronised `pwr_key_n` is 0 or `chg_det` is 1, while `lowbat_rst_n` is 1. When no wake input is active, the block stays off, with `supply_en`=0 and `ctl_rst_n`=0.
- R2: While running (`ctl_rst_n`=1), `pwr_key_n` and `chg_det` have no effect on either output.
- R3: `lowbat_rst_n`=0 sends the block to off from any state and blocks power-up. A change on any pin input reaches the outputs SYNC_STAGES+1 clock edges after it is sampled.
- R4: `ctl_rst_n` stays 0 while `pll_hold_n` is 0. After `pll_hold_n` has been 1 for HOLD_CYCLES cycles at the sequencer, `ctl_rst_n` goes to 1. A return of `pll_hold_n` to 0 during the hold restarts the count. If the PLL is already settled, `supply_en` is 1 with `ctl_rst_n` 0 for exactly HOLD_CYCLES+1 cycles.
- R5: After reset, both outputs are 0. `ctl_rst_n`=1 is never seen with `supply_en`=0.
- R6: While running without a kick, `ctl_rst_n` stays 1 for exactly WDOG_CYCLES cycles. Both outputs then fall to 0 together.
- R7: A `wd_kick` pulse while running restarts the watchdog window, so the block keeps running for WDOG_CYCLES cycles from the kick. A kick in the very cycle the window would expire still wins.
- R8: An `off_req` pulse while running drops both outputs on the next edge, even when a kick arrives in the same cycle. `off_req` has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| pwr_key_n | input | 1 | Power key, active low, wake source only |
| chg_det | input | 1 | Charger detected, active high, wake source only |
| lowbat_rst_n | input | 1 | Low-battery reset, active low, forces off |
| pll_hold_n | input | 1 | PLL settle delay, 0 while the PLL is still settling |
| wd_kick | input | 1 | One-cycle watchdog reload strobe from software |
| off_req | input | 1 | One-cycle software power-off strobe |
| supply_en | output | 1 | Enable for the receiver regulator and the controller |
| ctl_rst_n | output | 1 | Controller reset, active low |

## Verification
Two pairs of functions can meet in one cycle. The first is a watchdog reload and a watchdog expiry. The bench counts the cycles after a kick and places a second kick on the exact edge where the window would close. The run must then continue for a full fresh window. The second is a power-off request and a kick in the same cycle, where the power-off must win. For both pairs, the bench computes the expected cycle counts from HOLD_CYCLES, WDOG_CYCLES and SYNC_STAGES. It then compares them with the number of sampled cycles for which each output level lasted.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_SUPPLY  = 2'd1,
    PS_WAITPLL = 2'd2,
    PS_RUN     = 2'd3
  } pwr_state_e;

  // bit positions inside the synchronised pin vector
  localparam int PIN_KEY  = 0;
  localparam int PIN_CHG  = 1;
  localparam int PIN_LOWB = 2;
  localparam int PIN_PLL  = 3;
  localparam int PIN_NUM  = 4;

  // counter width able to hold values 0 .. lim-1
  function automatic int cnt_bits(input int lim);
    return (lim > 2) ? $clog2(lim) : 1;
  endfunction

  // wake condition: key pressed (low) or charger present
  function automatic logic wake_req(input logic key_n, input logic chg);
    return (!key_n) || chg;
  endfunction

endpackage

// File: rtl/pwr_sup_sync.sv
module pwr_sup_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pwr_sup_hold.sv
module pwr_sup_hold
  import pwr_sup_pkg::*;
#(
  parameter int HOLD_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic settled,
  output logic done
);

  localparam int CW = cnt_bits(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = active && settled && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!active || !settled) cnt <= '0;
    else if (done)               cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R4
  hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !settled) |=> !done);

endmodule

// File: rtl/pwr_sup_wdog.sv
module pwr_sup_wdog
  import pwr_sup_pkg::*;
#(
  parameter int WDOG_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic kick,
  output logic expire
);

  localparam int CW = cnt_bits(WDOG_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expire = arm && !kick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!arm || kick)    cnt <= '0;
    else if (cnt == LAST)     cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R7
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && kick) |=> !expire);

endmodule

// File: rtl/pwr_sup.sv
module pwr_sup
  import pwr_sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1024,
  parameter int WDOG_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_key_n,
  input  logic chg_det,
  input  logic lowbat_rst_n,
  input  logic pll_hold_n,
  input  logic wd_kick,
  input  logic off_req,
  output logic supply_en,
  output logic ctl_rst_n
);

  // reset values: key released, no charger, battery low, PLL unsettled
  localparam logic [PIN_NUM-1:0] PIN_IDLE = PIN_NUM'(1) << PIN_KEY;

  logic [PIN_NUM-1:0] pin_raw, pin_s;
  logic key_s, chg_s, lb_s, pll_s;
  logic hold_done, wd_expire, in_run, in_wait, wake;
  pwr_state_e cur, nxt;

  assign pin_raw[PIN_KEY]  = pwr_key_n;
  assign pin_raw[PIN_CHG]  = chg_det;
  assign pin_raw[PIN_LOWB] = lowbat_rst_n;
  assign pin_raw[PIN_PLL]  = pll_hold_n;

  pwr_sup_sync #(
    .WIDTH  (PIN_NUM),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (pin_s)
  );

  assign key_s = pin_s[PIN_KEY];
  assign chg_s = pin_s[PIN_CHG];
  assign lb_s  = pin_s[PIN_LOWB];
  assign pll_s = pin_s[PIN_PLL];

  assign in_run  = (cur == PS_RUN);
  assign in_wait = (cur == PS_WAITPLL);
  assign wake    = wake_req(key_s, chg_s);

  pwr_sup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (in_wait),
    .settled(pll_s),
    .done   (hold_done)
  );

  pwr_sup_wdog #(.WDOG_CYCLES(WDOG_CYCLES)) wdog_i (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (in_run),
    .kick  (wd_kick),
    .expire(wd_expire)
  );

  always_comb begin
    nxt = cur;
    if (!lb_s) begin
      nxt = PS_OFF;
    end else begin
      unique case (cur)
        PS_OFF:     if (wake) nxt = PS_SUPPLY;
        PS_SUPPLY:  nxt = PS_WAITPLL;
        PS_WAITPLL: if (hold_done) nxt = PS_RUN;
        PS_RUN:     if (off_req || wd_expire) nxt = PS_OFF;
        default:    nxt = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= PS_OFF;
    else        cur <= nxt;
  end

  assign supply_en = (cur != PS_OFF);
  assign ctl_rst_n = in_run;

  // R1
  no_spurious_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_OFF && key_s && !chg_s) |=> (cur == PS_OFF));

  // R2
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && lb_s && !off_req && !wd_expire) |=> in_run);

  // R3
  lowbat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_s |=> (cur == PS_OFF));

  // R4
  release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rst_n) |-> $past(hold_done));

  // R5
  rst_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst_n |-> supply_en);

  // R6
  wdog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> !supply_en);

  // R8
  sw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && off_req) |=> !supply_en);

endmodule

// File: tb/pwr_sup_tb.sv
`timescale 1ns/1ps
module pwr_sup_tb_top;

  localparam int S    = 2;
  localparam int HOLD = 16;
  localparam int WDOG = 64;

  logic clk = 1'b0;
  logic rst_n, key_n, chg, lowb_n, pll_n, kick, offr;
  logic sup, crst_n;

  int tests = 0;
  int fails = 0;
  int bad_pairs = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  pwr_sup #(.SYNC_STAGES(S), .HOLD_CYCLES(HOLD), .WDOG_CYCLES(WDOG)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_key_n(key_n), .chg_det(chg),
    .lowbat_rst_n(lowb_n), .pll_hold_n(pll_n), .wd_kick(kick),
    .off_req(offr), .supply_en(sup), .ctl_rst_n(crst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5 monitor: reset released without supply
  always @(negedge clk) if (rst_n && crst_n && !sup) bad_pairs++;

  // wait until ctl_rst_n reaches level, bounded
  task automatic wait_rst(input logic lvl);
    for (int i = 0; i < 400; i++) begin
      if (crst_n == lvl) return;
      @(negedge clk);
    end
  endtask

  task automatic power_up_key();
    key_n = 1'b0;
    for (int i = 0; i < 20 && !sup; i++) @(negedge clk);
    key_n = 1'b1;
    wait_rst(1'b1);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; key_n = 1; chg = 0; lowb_n = 1; pll_n = 1; kick = 0; offr = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset supply", int'(sup), 0);
    chk("R5 reset ctl", int'(crst_n), 0);
    rst_n = 1;

    // R1: idle stays off
    repeat (10) @(negedge clk);
    chk("R1 idle off", int'(sup), 0);

    // R3: low battery blocks a key press
    lowb_n = 0; key_n = 0;
    repeat (10) @(negedge clk);
    chk("R3 blocked start", int'(sup), 0);
    lowb_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!sup && n < 50);
    chk("R3 pin latency", n, S + 1);
    key_n = 1;
    // R4: PLL already settled, hold length seen at the ports
    n = 1;
    while (!crst_n && n < 400) begin @(negedge clk); if (!crst_n) n++; end
    chk("R4 hold length", n, HOLD + 1);
    // R6: unkicked run length
    n = 0;
    while (crst_n && n < 400) begin n++; @(negedge clk); end
    chk("R6 wdog window", n, WDOG);
    chk("R6 supply dropped", int'(sup), 0);

    // R4: charger start with PLL unsettled
    pll_n = 0; chg = 1;
    for (int i = 0; i < 20 && !sup; i++) @(negedge clk);
    chg = 0;
    chk("R1 charger wake", int'(sup), 1);
    repeat (40) @(negedge clk);
    chk("R4 held while PLL low", int'(crst_n), 0);
    // R8: off request outside run is ignored
    offr = 1; @(negedge clk); offr = 0;
    repeat (2) @(negedge clk);
    chk("R8 off ignored in wait", int'(sup), 1);
    // R4: partial settle then drop restarts
    pll_n = 1; repeat (HOLD - 4) @(negedge clk);
    pll_n = 0; repeat (S + 3) @(negedge clk);
    chk("R4 restart still held", int'(crst_n), 0);
    pll_n = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!crst_n && n < 400);
    chk("R4 settle to release", n, S + HOLD);

    // R2: key and charger ignored while running and kicked
    key_n = 0; chg = 1;
    for (int k = 0; k < 5; k++) begin
      repeat (19) @(negedge clk);
      kick = 1; @(negedge clk); kick = 0;
    end
    chk("R2 run kept", int'(crst_n), 1);
    key_n = 1; chg = 0;
    repeat (S + 2) @(negedge clk);
    chk("R2 run after release", int'(crst_n), 1);

    // R7: kick on the expiry cycle wins
    kick = 1; @(negedge clk); kick = 0;
    repeat (WDOG - 1) @(negedge clk);
    chk("R7 alive before last", int'(crst_n), 1);
    kick = 1; @(negedge clk); kick = 0;
    chk("R7 late kick won", int'(crst_n), 1);
    n = 1;
    while (n < 400) begin @(negedge clk); if (!crst_n) break; n++; end
    chk("R7 fresh window", n, WDOG);

    // R8: off request and kick in the same cycle
    power_up_key();
    repeat (3) @(negedge clk);
    offr = 1; kick = 1; @(negedge clk); offr = 0; kick = 0;
    chk("R8 off beats kick supply", int'(sup), 0);
    chk("R8 off beats kick ctl", int'(crst_n), 0);

    // R3: low battery while running
    power_up_key();
    lowb_n = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (sup && n < 50);
    chk("R3 run to off latency", n, S + 1);
    lowb_n = 1;
    repeat (10) @(negedge clk);
    chk("R1 no restart without wake", int'(sup), 0);

    chk("R5 reset never without supply", bad_pairs, 0);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule